// File: doc/BRIEF.md
# Multi-Mode Operand Address and Fetch Unit

This unit resolves the source operand of an add-type instruction under ten addressing modes. A start strobe captures a mode code, two register indices, an instruction field holding a displacement, immediate or absolute address, and a size code that selects the operand width d in bytes. The unit reads the base and index registers through two combinational register-file read ports, forms the effective address, and then issues one or two reads on a single-port memory interface. Each read holds its request until the memory signals valid.

Auto-increment and auto-decrement modes also write the base register back through the register-file write port. This write happens once, after the operand read, and the address always uses the register value from before the update. The operand is presented together with a one-cycle done pulse. Mode codes outside the ten defined ones raise an illegal flag on that done pulse and cause no memory access and no register write. Decode, the adder and the destination write-back sit outside this block.

Top module: `opnd_fetch_unit`

## Requirements
- R1: While reset is high and in the first cycle after it, done, illegal, mem_req and rf_we are all low.
- R2: Mode 0 (register) returns the base register value and mode 1 (immediate) returns the instruction field. Neither issues a memory request, and done is high in the second cycle after the cycle in which start is sampled.
- R3: Mode 2 reads at field plus base, mode 3 reads at base, and mode 5 reads at the field taken as an absolute address. In each case the read data is the operand.
- R4: Mode 4 reads at base plus index. Mode 9 reads at field plus base plus (index shifted left by the size code). The size code values 0, 1, 2 and 3 stand for d of 1, 2, 4 and 8 bytes. All address sums wrap modulo 2^W.
- R5: Mode 6 reads at base, then issues a second read whose address is the data of the first read. The data of the second read is the operand.
- R6: Mode 7 (auto-increment) and mode 8 (auto-decrement) read at the unchanged base. In the cycle after the read completes, they assert rf_we once, with the base index and base plus d (mode 7) or base minus d (mode 8). Done follows in the next cycle. No other mode asserts rf_we.
- R7: mem_req stays high with a stable mem_addr until the cycle in which mem_valid is high. mem_valid is ignored in any cycle without a request.
- R8: Mode codes 10 to 15 give done with illegal high and operand 0, with no memory request and no register write.
- R9: Done is a one-cycle pulse. Start, and any change of the mode, index, field or size inputs, are ignored from the cycle after start is sampled until the cycle after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins an operand fetch when the unit is idle |
| mode_sel | input | 4 | Addressing mode code |
| base_sel | input | RIW | Base register index |
| index_sel | input | RIW | Index register index |
| imm_field | input | W | Displacement, immediate or absolute address |
| size_code | input | 2 | Operand size, d = 1 << size_code bytes |
| rf_rd_a_idx | output | RIW | Register read port A index (base) |
| rf_rd_a_data | input | W | Register read port A data |
| rf_rd_b_idx | output | RIW | Register read port B index (index) |
| rf_rd_b_data | input | W | Register read port B data |
| rf_we | output | 1 | Base register write enable |
| rf_wa | output | RIW | Base register write index |
| rf_wd | output | W | Updated base register value |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | W | Memory read address |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | W | Read data |
| operand | output | W | Fetched operand, valid with done |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Unused mode code, valid with done |

## Verification
Two things can land in the same cycle: a new start strobe, with changed mode and field inputs, and an operand fetch that is still in its address, read or update phase. A mem_valid can also arrive in a cycle with no request. To provoke this, the bench runs several fetches with start held high and different inputs driven throughout the busy window, and pulses mem_valid during the address and update cycles. The per-cycle reference model then checks that the request address, the write-back and the operand match the captured instruction only, and that no extra fetch begins.

// File: rtl/opf_pkg.sv
package opf_pkg;

    typedef enum logic [3:0] {
        AM_REG    = 4'd0,
        AM_IMM    = 4'd1,
        AM_DISP   = 4'd2,
        AM_RIND   = 4'd3,
        AM_INDEX  = 4'd4,
        AM_ABS    = 4'd5,
        AM_MIND   = 4'd6,
        AM_AINC   = 4'd7,
        AM_ADEC   = 4'd8,
        AM_SCALED = 4'd9
    } amode_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_READ1,
        S_READ2,
        S_UPDATE,
        S_DONE
    } fetch_state_e;

    typedef struct packed {
        logic legal;
        logic uses_mem;
        logic two_reads;
        logic auto_upd;
        logic auto_dec;
    } mode_info_t;

    function automatic mode_info_t decode_mode(input logic [3:0] code);
        mode_info_t mi;
        mi = '0;
        mi.legal     = (code <= 4'd9);
        mi.uses_mem  = mi.legal && (code != AM_REG) && (code != AM_IMM);
        mi.two_reads = (code == AM_MIND);
        mi.auto_upd  = (code == AM_AINC) || (code == AM_ADEC);
        mi.auto_dec  = (code == AM_ADEC);
        return mi;
    endfunction

endpackage

// File: rtl/opf_addr_gen.sv
module opf_addr_gen
    import opf_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [3:0]   mode,
    input  logic [W-1:0] base_val,
    input  logic [W-1:0] index_val,
    input  logic [W-1:0] field,
    input  logic [1:0]   size_code,
    output logic [W-1:0] ea,
    output logic [W-1:0] base_next
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] step;
    logic [W-1:0] scaled_index;
    mode_info_t   mi;

    always_comb begin
        step         = ONE << size_code;
        scaled_index = index_val << size_code;
        mi           = decode_mode(mode);
        case (mode)
            AM_DISP:   ea = field + base_val;
            AM_INDEX:  ea = base_val + index_val;
            AM_ABS:    ea = field;
            AM_SCALED: ea = field + base_val + scaled_index;
            default:   ea = base_val;
        endcase
        base_next = mi.auto_dec ? (base_val - step) : (base_val + step);
    end

endmodule

// File: rtl/opf_seq.sv
module opf_seq
    import opf_pkg::*;
#(
    parameter int W   = 16,
    parameter int RIW = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [3:0]     mode_in,
    input  logic [RIW-1:0] base_in,
    input  logic [RIW-1:0] index_in,
    input  logic [W-1:0]   field_in,
    input  logic [1:0]     size_in,
    output logic [3:0]     cur_mode,
    output logic [RIW-1:0] cur_base,
    output logic [RIW-1:0] cur_index,
    output logic [W-1:0]   cur_field,
    output logic [1:0]     cur_size,
    input  logic [W-1:0]   ea,
    input  logic [W-1:0]   base_next,
    input  logic [W-1:0]   base_val,
    output logic           mem_req,
    output logic [W-1:0]   mem_addr,
    input  logic           mem_valid,
    input  logic [W-1:0]   mem_rdata,
    output logic           rf_we,
    output logic [RIW-1:0] rf_wa,
    output logic [W-1:0]   rf_wd,
    output logic [W-1:0]   operand,
    output logic           done,
    output logic           illegal
);
    fetch_state_e   state_q;
    logic [3:0]     mode_q;
    logic [RIW-1:0] base_q;
    logic [RIW-1:0] index_q;
    logic [W-1:0]   field_q;
    logic [1:0]     size_q;
    logic [W-1:0]   addr_q;
    logic [W-1:0]   wb_q;
    logic [W-1:0]   res_q;
    logic           ill_q;
    mode_info_t     info;

    assign info = decode_mode(mode_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            mode_q  <= '0;
            base_q  <= '0;
            index_q <= '0;
            field_q <= '0;
            size_q  <= '0;
            addr_q  <= '0;
            wb_q    <= '0;
            res_q   <= '0;
            ill_q   <= 1'b0;
        end else begin
            case (state_q)
                S_IDLE: begin
                    if (start) begin
                        mode_q  <= mode_in;
                        base_q  <= base_in;
                        index_q <= index_in;
                        field_q <= field_in;
                        size_q  <= size_in;
                        res_q   <= '0;
                        ill_q   <= 1'b0;
                        state_q <= S_ADDR;
                    end
                end
                S_ADDR: begin
                    if (!info.legal) begin
                        ill_q   <= 1'b1;
                        state_q <= S_DONE;
                    end else if (!info.uses_mem) begin
                        res_q   <= (mode_q == AM_IMM) ? field_q : base_val;
                        state_q <= S_DONE;
                    end else begin
                        addr_q  <= ea;
                        wb_q    <= base_next;
                        state_q <= S_READ1;
                    end
                end
                S_READ1: begin
                    if (mem_valid) begin
                        if (info.two_reads) begin
                            addr_q  <= mem_rdata;
                            state_q <= S_READ2;
                        end else begin
                            res_q   <= mem_rdata;
                            state_q <= info.auto_upd ? S_UPDATE : S_DONE;
                        end
                    end
                end
                S_READ2: begin
                    if (mem_valid) begin
                        res_q   <= mem_rdata;
                        state_q <= S_DONE;
                    end
                end
                S_UPDATE: state_q <= S_DONE;
                S_DONE:   state_q <= S_IDLE;
                default:  state_q <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        cur_mode  = mode_q;
        cur_base  = base_q;
        cur_index = index_q;
        cur_field = field_q;
        cur_size  = size_q;
        mem_req   = (state_q == S_READ1) || (state_q == S_READ2);
        mem_addr  = addr_q;
        rf_we     = (state_q == S_UPDATE);
        rf_wa     = base_q;
        rf_wd     = wb_q;
        done      = (state_q == S_DONE);
        operand   = res_q;
        illegal   = done && ill_q;
    end

    // Request holds with a steady address until the handshake completes
    assert_req_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

    // Completion is a single-cycle pulse
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // Base write-back is followed directly by completion, and only in auto modes
    assert_wb_then_done_R6: assert property (@(posedge clk) disable iff (rst)
        rf_we |=> done);
    assert_wb_auto_only_R6: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> (mode_q == AM_AINC || mode_q == AM_ADEC));

    // Illegal completion comes straight from address phase: no read, no write
    assert_illegal_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        illegal |-> ($past(state_q) == S_ADDR));

endmodule

// File: rtl/opnd_fetch_unit.sv
module opnd_fetch_unit
    import opf_pkg::*;
#(
    parameter int W    = 16,
    parameter int NREG = 16,
    localparam int RIW = $clog2(NREG)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [3:0]     mode_sel,
    input  logic [RIW-1:0] base_sel,
    input  logic [RIW-1:0] index_sel,
    input  logic [W-1:0]   imm_field,
    input  logic [1:0]     size_code,
    output logic [RIW-1:0] rf_rd_a_idx,
    input  logic [W-1:0]   rf_rd_a_data,
    output logic [RIW-1:0] rf_rd_b_idx,
    input  logic [W-1:0]   rf_rd_b_data,
    output logic           rf_we,
    output logic [RIW-1:0] rf_wa,
    output logic [W-1:0]   rf_wd,
    output logic           mem_req,
    output logic [W-1:0]   mem_addr,
    input  logic           mem_valid,
    input  logic [W-1:0]   mem_rdata,
    output logic [W-1:0]   operand,
    output logic           done,
    output logic           illegal
);
    logic [3:0]     cur_mode;
    logic [RIW-1:0] cur_base;
    logic [RIW-1:0] cur_index;
    logic [W-1:0]   cur_field;
    logic [1:0]     cur_size;
    logic [W-1:0]   ea;
    logic [W-1:0]   base_next;

    assign rf_rd_a_idx = cur_base;
    assign rf_rd_b_idx = cur_index;

    opf_addr_gen #(.W(W)) u_addr (
        .mode      (cur_mode),
        .base_val  (rf_rd_a_data),
        .index_val (rf_rd_b_data),
        .field     (cur_field),
        .size_code (cur_size),
        .ea        (ea),
        .base_next (base_next)
    );

    opf_seq #(.W(W), .RIW(RIW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .mode_in   (mode_sel),
        .base_in   (base_sel),
        .index_in  (index_sel),
        .field_in  (imm_field),
        .size_in   (size_code),
        .cur_mode  (cur_mode),
        .cur_base  (cur_base),
        .cur_index (cur_index),
        .cur_field (cur_field),
        .cur_size  (cur_size),
        .ea        (ea),
        .base_next (base_next),
        .base_val  (rf_rd_a_data),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_valid (mem_valid),
        .mem_rdata (mem_rdata),
        .rf_we     (rf_we),
        .rf_wa     (rf_wa),
        .rf_wd     (rf_wd),
        .operand   (operand),
        .done      (done),
        .illegal   (illegal)
    );

endmodule

// File: tb/test_opnd_fetch_unit.sv
module test_opnd_fetch_unit;
    localparam int W = 16;
    localparam int NREG = 16;
    localparam int RIW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [3:0] mode_sel = '0;
    logic [RIW-1:0] base_sel = '0, index_sel = '0;
    logic [W-1:0] imm_field = '0;
    logic [1:0] size_code = '0;
    logic [RIW-1:0] rf_rd_a_idx, rf_rd_b_idx, rf_wa;
    logic [W-1:0] rf_rd_a_data, rf_rd_b_data, rf_wd;
    logic rf_we, mem_req, done, illegal;
    logic [W-1:0] mem_addr, operand;
    logic mem_valid = 1'b0;
    logic [W-1:0] mem_rdata = '0;

    logic [W-1:0] regs [NREG];
    logic [W-1:0] mregs [NREG];
    logic [W-1:0] mem [256];

    int checks = 0;
    int fails = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    opnd_fetch_unit #(.W(W), .NREG(NREG)) i_opnd_fetch_unit (
        .clk(clk), .rst(rst), .start(start), .mode_sel(mode_sel),
        .base_sel(base_sel), .index_sel(index_sel), .imm_field(imm_field),
        .size_code(size_code), .rf_rd_a_idx(rf_rd_a_idx), .rf_rd_a_data(rf_rd_a_data),
        .rf_rd_b_idx(rf_rd_b_idx), .rf_rd_b_data(rf_rd_b_data), .rf_we(rf_we),
        .rf_wa(rf_wa), .rf_wd(rf_wd), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_valid(mem_valid), .mem_rdata(mem_rdata), .operand(operand),
        .done(done), .illegal(illegal)
    );

    function automatic logic [W-1:0] reg_init(input int i);
        return W'(16'h0100 + i * 16'h0013);
    endfunction

    // Register file attached to the unit
    assign rf_rd_a_data = regs[rf_rd_a_idx];
    assign rf_rd_b_data = regs[rf_rd_b_idx];
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= reg_init(i);
        end else if (rf_we) begin
            regs[rf_wa] <= rf_wd;
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 50000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One fetch, checked cycle by cycle against a behavioural model
    task automatic run_op(input logic [3:0] m, input int b, input int x,
                          input logic [W-1:0] f, input logic [1:0] sz,
                          input int lat, input bit noise, input string req);
        logic [W-1:0] bv, xv, d, a1, res, nb;
        logic [W-1:0] addrs[$];
        bit upd, ill;
        bv = mregs[b]; xv = mregs[x]; d = W'(1) << sz;
        upd = 0; ill = 0; res = '0; nb = bv;
        case (m)
            4'd0: res = bv;
            4'd1: res = f;
            4'd2: addrs.push_back(f + bv);
            4'd3: addrs.push_back(bv);
            4'd4: addrs.push_back(bv + xv);
            4'd5: addrs.push_back(f);
            4'd6: begin addrs.push_back(bv); addrs.push_back(mem[bv[7:0]]); end
            4'd7: begin addrs.push_back(bv); upd = 1; nb = bv + d; end
            4'd8: begin addrs.push_back(bv); upd = 1; nb = bv - d; end
            4'd9: addrs.push_back(f + bv + (xv * d));
            default: ill = 1;
        endcase
        if (addrs.size() > 0) res = mem[addrs[addrs.size()-1][7:0]];

        @(negedge clk);
        start = 1; mode_sel = m; base_sel = RIW'(b); index_sel = RIW'(x);
        imm_field = f; size_code = sz;
        @(negedge clk); // address phase
        if (noise) begin
            mode_sel = 4'd1; imm_field = 16'hBEEF; base_sel = 4'd0; mem_valid = 1;
            mem_rdata = 16'h5555;
        end else start = 0;
        chk(!mem_req && !rf_we && !done, req, "quiet address phase",
            {13'd0, mem_req, rf_we, done}, '0);
        for (int r = 0; r < addrs.size(); r++) begin
            a1 = addrs[r];
            for (int c = 1; c <= lat; c++) begin
                @(negedge clk);
                chk(mem_req === 1'b1, "R7", "request held", W'(mem_req), 1);
                chk(mem_addr === a1, req, "read address", mem_addr, a1);
                mem_valid = (c == lat);
                mem_rdata = (c == lat) ? mem[a1[7:0]] : 16'hDEAD;
            end
        end
        if (upd) begin
            @(negedge clk);
            mem_valid = noise; mem_rdata = 16'h7777;
            chk(rf_we === 1'b1 && !mem_req, "R6", "write-back strobe", W'(rf_we), 1);
            chk(rf_wa === RIW'(b), "R6", "write-back index", W'(rf_wa), W'(b));
            chk(rf_wd === nb, "R6", "write-back value", rf_wd, nb);
            mregs[b] = nb;
        end
        @(negedge clk);
        mem_valid = 0; start = 0;
        chk(done === 1'b1, req, "done", W'(done), 1);
        chk(operand === res, req, "operand", operand, res);
        chk(illegal === ill, ill ? "R8" : req, "illegal flag", W'(illegal), W'(ill));
        chk(!mem_req && !rf_we, req, "no access at done", W'({mem_req, rf_we}), 0);
        @(negedge clk);
        chk(!done && !mem_req && !rf_we, "R9", "single done pulse and idle",
            W'({done, mem_req, rf_we}), 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = W'(16'hA000 ^ (i * 16'h0107));
        for (int i = 0; i < NREG; i++) mregs[i] = reg_init(i);
        repeat (3) @(negedge clk);
        chk(!done && !illegal && !mem_req && !rf_we, "R1", "outputs in reset",
            W'({done, illegal, mem_req, rf_we}), 0);
        rst = 0;
        @(negedge clk);
        chk(!done && !illegal && !mem_req && !rf_we, "R1", "outputs after reset",
            W'({done, illegal, mem_req, rf_we}), 0);

        run_op(4'd0, 3, 0, 16'h0000, 2'd0, 1, 0, "R2");
        run_op(4'd1, 0, 0, 16'h1234, 2'd0, 1, 0, "R2");
        run_op(4'd2, 2, 0, 16'h0010, 2'd0, 1, 0, "R3");
        run_op(4'd3, 5, 0, 16'h0000, 2'd0, 3, 0, "R3");
        run_op(4'd5, 0, 0, 16'h0042, 2'd0, 2, 0, "R3");
        run_op(4'd4, 4, 6, 16'h0000, 2'd0, 2, 0, "R4");
        for (int s = 0; s < 4; s++)
            run_op(4'd9, 1, 2, 16'h0020, 2'(s), 1 + s, 0, "R4");
        run_op(4'd9, 15, 14, 16'hFFF0, 2'd3, 1, 0, "R4");
        run_op(4'd6, 7, 0, 16'h0000, 2'd0, 2, 0, "R5");
        run_op(4'd6, 11, 0, 16'h0000, 2'd0, 1, 1, "R5");
        run_op(4'd7, 8, 0, 16'h0000, 2'd2, 1, 0, "R6");
        run_op(4'd0, 8, 0, 16'h0000, 2'd0, 1, 0, "R6");
        run_op(4'd8, 9, 0, 16'h0000, 2'd3, 2, 0, "R6");
        run_op(4'd0, 9, 0, 16'h0000, 2'd0, 1, 0, "R6");
        run_op(4'd7, 8, 0, 16'h0000, 2'd0, 3, 1, "R6");
        run_op(4'd8, 8, 0, 16'h0000, 2'd1, 1, 1, "R6");
        run_op(4'd3, 8, 0, 16'h0000, 2'd0, 1, 0, "R6");
        run_op(4'd10, 8, 0, 16'h0000, 2'd2, 1, 0, "R8");
        run_op(4'd15, 8, 0, 16'h0000, 2'd2, 1, 1, "R8");
        run_op(4'd0, 8, 0, 16'h0000, 2'd0, 1, 0, "R8");
        run_op(4'd2, 3, 0, 16'h0004, 2'd0, 4, 1, "R9");
        run_op(4'd0, 0, 0, 16'h0000, 2'd0, 1, 1, "R9");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule